// File: doc/BRIEF.md
# Transmit Byte Queue with Frame Invalidation

This block is a byte-wide first-in first-out queue. Software fills it from one side. A serial frame transmitter drains it from the other side, one byte for each response field. The block raises a sticky level trigger while the queue holds fewer bytes than a programmed threshold, so software knows when to refill it. It also watches for two misuse cases: a software write into a full queue, and a transmitter read from an empty queue.

Neither misuse case stops the frame that is on the bus. Instead the block raises a request that the transmitter send the frame's check value bit-inverted, so every receiver rejects the frame. It also raises a request to clear the pending header-transmit and response-transmit commands. The invert request lasts until the transmitter reports the end of the frame. The command-clear request lasts until the command logic acknowledges it.

Top module: `txq_guard`

## Requirements
- R1: Bytes leave in the order they were accepted. The oldest stored byte is shown on `eng_rdata` without waiting for a clock edge, and an `eng_rd` strobe at a clock edge removes it. The queue holds up to DEPTH bytes.
- R2: `trig_flag` is high in the cycle after any clock edge at which the stored byte count was strictly less than `trig_level`. The flag is sticky. With `trig_level` = 0 it never sets.
- R3: A `sw_wr` at an edge where DEPTH bytes are already stored is dropped. Stored bytes are left unchanged, and `ovf_flag` is high from the next cycle.
- R4: An `eng_rd` at an edge where the queue is empty reads 0x00 on `eng_rdata` and does not move the read position. `unf_flag` is high from the next cycle. A write in the same cycle is still accepted.
- R5: `flag_clr` is write-one-to-clear with one bit per flag: bit 0 clears `trig_flag`, bit 1 clears `ovf_flag`, bit 2 clears `unf_flag`. The cleared value appears in the next cycle. The trigger sets again at once if its condition still holds at that edge.
- R6: After an overflow or underflow edge, `invert_req` is high from the next cycle until an edge with `frame_end` high. A new error at that same edge keeps it high.
- R7: After an overflow or underflow edge, `cmd_clr` is high from the next cycle until an edge with `cmd_clr_ack` high. A new error at that same edge keeps it high.
- R8: While `rst_n` is low, the queue is empty and all flags, `invert_req`, `cmd_clr` and `eng_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | W | Byte written by software |
| eng_rd | input | 1 | Transmitter read strobe |
| eng_rdata | output | W | Oldest stored byte, 0 when the queue is empty |
| trig_level | input | CW | Refill threshold compared with the stored byte count |
| flag_clr | input | 3 | Write-one-to-clear strobes {underflow, overflow, trigger} |
| frame_end | input | 1 | Transmitter end-of-frame pulse |
| cmd_clr_ack | input | 1 | Acknowledge of the command-clear request |
| trig_flag | output | 1 | Sticky refill trigger |
| ovf_flag | output | 1 | Sticky overflow error |
| unf_flag | output | 1 | Sticky underflow error |
| invert_req | output | 1 | Request to send the frame check value inverted |
| cmd_clr | output | 1 | Request to clear the transmit commands |

## Verification
`eng_rdata` depends only on stored state, so the bench reads it at the falling edge before the strobe that consumes the byte. Every flag and request is one register stage behind its cause: the bench drives inputs at a falling edge, lets one rising edge pass, and checks the outputs at the following falling edge. Same-edge races are driven on purpose in single cycles: a write together with an underflowing read, an error together with `frame_end` and `cmd_clr_ack`, and a trigger clear while the trigger condition still holds.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int NFLAG = 3;
  localparam int FL_TRIG = 0;
  localparam int FL_OVF  = 1;
  localparam int FL_UNF  = 2;

  // next position in a circular store of 'depth' slots
  function automatic int ring_step(input int pos, input int depth);
    return (pos == depth - 1) ? 0 : pos + 1;
  endfunction

  // occupancy after one edge with an accepted push and/or pop
  function automatic int occ_after(input int occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] occ
);
  import txq_pkg::*;

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) slots[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= AW'(ring_step(int'(wptr), DEPTH));
      if (pop)  rptr <= AW'(ring_step(int'(rptr), DEPTH));
      occ <= CW'(occ_after(int'(occ), push, pop));
    end
  end

  assign head = slots[rptr];
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= (flag[i] & ~clr[i]) | set_ev[i];
    end
  end
endmodule

// File: rtl/txq_invalidate.sv
module txq_invalidate (
  input  logic clk,
  input  logic rst_n,
  input  logic err,
  input  logic frame_end,
  input  logic ack,
  output logic invert_req,
  output logic cmd_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invert_req <= 1'b0;
      cmd_clr    <= 1'b0;
    end else begin
      // a fresh error outranks the release event on the same edge
      if (err)            invert_req <= 1'b1;
      else if (frame_end) invert_req <= 1'b0;
      if (err)            cmd_clr <= 1'b1;
      else if (ack)       cmd_clr <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_guard.sv
module txq_guard #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [W-1:0]  sw_wdata,
  input  logic          eng_rd,
  output logic [W-1:0]  eng_rdata,
  input  logic [CW-1:0] trig_level,
  input  logic [2:0]    flag_clr,
  input  logic          frame_end,
  input  logic          cmd_clr_ack,
  output logic          trig_flag,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          invert_req,
  output logic          cmd_clr
);
  import txq_pkg::*;

  logic [CW-1:0]    occ;
  logic [W-1:0]     head;
  logic             q_full, q_empty;
  logic             ovf_evt, unf_evt, push, pop, trig_cond;
  logic [NFLAG-1:0] set_vec, flag_vec;

  assign q_full    = (occ == CW'(DEPTH));
  assign q_empty   = (occ == '0);
  assign ovf_evt   = sw_wr & q_full;
  assign unf_evt   = eng_rd & q_empty;
  assign push      = sw_wr & ~q_full;
  assign pop       = eng_rd & ~q_empty;
  assign trig_cond = (occ < trig_level);

  txq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(sw_wdata),
    .pop(pop), .head(head), .occ(occ)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FL_TRIG] = trig_cond;
    set_vec[FL_OVF]  = ovf_evt;
    set_vec[FL_UNF]  = unf_evt;
  end

  txq_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_vec), .clr(flag_clr), .flag(flag_vec)
  );

  assign trig_flag = flag_vec[FL_TRIG];
  assign ovf_flag  = flag_vec[FL_OVF];
  assign unf_flag  = flag_vec[FL_UNF];

  txq_invalidate u_inval (
    .clk(clk), .rst_n(rst_n), .err(ovf_evt | unf_evt), .frame_end(frame_end),
    .ack(cmd_clr_ack), .invert_req(invert_req), .cmd_clr(cmd_clr)
  );

  assign eng_rdata = q_empty ? '0 : head;
endmodule

// File: rtl/txq_guard_chk.sv
module txq_guard_chk #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_wr,
  input logic          eng_rd,
  input logic          frame_end,
  input logic [CW-1:0] trig_level,
  input logic [W-1:0]  eng_rdata,
  input logic          trig_flag,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          invert_req,
  input logic          cmd_clr,
  input logic [CW-1:0] occ,
  input logic          ovf_evt,
  input logic          unf_evt
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occ <= CW'(DEPTH)); // R1
  AST_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n) (occ < trig_level) |=> trig_flag); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> ovf_flag); // R3
  AST_DROP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n) (sw_wr && occ == CW'(DEPTH) && !eng_rd) |=> occ == CW'(DEPTH)); // R3
  AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n) (eng_rd && occ == '0) |=> unf_flag); // R4
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) unf_evt |-> eng_rdata == '0); // R4
  AST_INVERT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) (ovf_evt || unf_evt) |=> invert_req); // R6
  AST_INVERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (invert_req && !frame_end) |=> invert_req); // R6
  AST_CMDCLR_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) (ovf_evt || unf_evt) |=> cmd_clr); // R7
  AST_ERR_ONLY_ON_MISUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(unf_flag) |-> $past(eng_rd)); // R4
endmodule

bind txq_guard txq_guard_chk #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .eng_rd(eng_rd), .frame_end(frame_end),
  .trig_level(trig_level), .eng_rdata(eng_rdata), .trig_flag(trig_flag),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag), .invert_req(invert_req),
  .cmd_clr(cmd_clr), .occ(occ), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
);

// File: tb/txq_guard_test.sv
module txq_guard_test;
  localparam int DEPTH = 4;
  localparam int W     = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 1'b0, eng_rd = 1'b0, frame_end = 1'b0, cmd_clr_ack = 1'b0;
  logic [W-1:0] sw_wdata = '0;
  logic [CW-1:0] trig_level = '0;
  logic [2:0] flag_clr = '0;
  logic [W-1:0] eng_rdata;
  logic trig_flag, ovf_flag, unf_flag, invert_req, cmd_clr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txq_guard #(.DEPTH(DEPTH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .eng_rd(eng_rd),
    .eng_rdata(eng_rdata), .trig_level(trig_level), .flag_clr(flag_clr),
    .frame_end(frame_end), .cmd_clr_ack(cmd_clr_ack), .trig_flag(trig_flag),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .invert_req(invert_req), .cmd_clr(cmd_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, pass one rising edge, return at the next falling edge
  task automatic step(input logic wr, input logic [W-1:0] wd, input logic rd,
                      input logic [2:0] clr, input logic fe, input logic ack);
    sw_wr = wr; sw_wdata = wd; eng_rd = rd; flag_clr = clr;
    frame_end = fe; cmd_clr_ack = ack;
    @(posedge clk);
    @(negedge clk);
    sw_wr = 1'b0; eng_rd = 1'b0; flag_clr = '0; frame_end = 1'b0; cmd_clr_ack = 1'b0;
  endtask

  // {wr, wdata, rd, expected rdata before edge, expected ovf after, expected unf after}
  typedef struct packed {
    logic wr; logic [7:0] wd; logic rd; logic [7:0] er; logic eo; logic eu;
  } vec_t;
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'hB2, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'hC3, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'hD4, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'hE5, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hA1, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hB2, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hC3, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hD4, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1},
    '{1'b1, 8'h66, 1'b0, 8'h00, 1'b1, 1'b1},
    '{1'b0, 8'h00, 1'b1, 8'h66, 1'b1, 1'b1},
    '{1'b1, 8'h77, 1'b1, 8'h00, 1'b1, 1'b1},
    '{1'b0, 8'h00, 1'b1, 8'h77, 1'b1, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 trig", trig_flag, 0); chk("R8 ovf", ovf_flag, 0); chk("R8 unf", unf_flag, 0);
    chk("R8 inv", invert_req, 0); chk("R8 cmd", cmd_clr, 0); chk("R8 rdata", eng_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].rd) chk(VT[i].eo ? "R1/R4 rdata" : "R1 rdata", eng_rdata, VT[i].er);
      step(VT[i].wr, VT[i].wd, VT[i].rd, 3'b000, 1'b0, 1'b0);
      chk("R3 ovf_flag", ovf_flag, VT[i].eo);
      chk("R4 unf_flag", unf_flag, VT[i].eu);
      if (i == 4) begin
        chk("R6 invert after overflow", invert_req, 1);
        chk("R7 cmd_clr after overflow", cmd_clr, 1);
      end
    end

    // R2 threshold 0 never triggers
    chk("R2 level zero", trig_flag, 0);
    trig_level = CW'(2);
    step(0, 0, 0, 3'b000, 0, 0);
    chk("R2 set below level", trig_flag, 1);
    step(1, 8'h11, 0, 3'b000, 0, 0);
    step(1, 8'h22, 0, 3'b000, 0, 0);
    step(1, 8'h33, 0, 3'b000, 0, 0);
    step(0, 0, 0, 3'b001, 0, 0);
    chk("R5 trig cleared at level 3", trig_flag, 0);
    chk("R1 head after refill", eng_rdata, 8'h11);
    step(0, 0, 1, 3'b000, 0, 0);
    chk("R1 second byte", eng_rdata, 8'h22);
    step(0, 0, 1, 3'b000, 0, 0);
    chk("R2 not set yet", trig_flag, 0);
    step(0, 0, 0, 3'b000, 0, 0);
    chk("R2 set at count 1", trig_flag, 1);
    step(0, 0, 0, 3'b001, 0, 0);
    chk("R5 trig reasserts", trig_flag, 1);
    chk("R1 last byte", eng_rdata, 8'h33);
    step(0, 0, 1, 3'b000, 0, 0);

    // R6 / R7 release
    step(0, 0, 0, 3'b000, 1, 0);
    chk("R6 frame_end releases", invert_req, 0);
    chk("R7 held without ack", cmd_clr, 1);
    step(0, 0, 0, 3'b000, 0, 1);
    chk("R7 ack releases", cmd_clr, 0);
    step(0, 0, 1, 3'b000, 1, 1);
    chk("R6 error beats frame_end", invert_req, 1);
    chk("R7 error beats ack", cmd_clr, 1);
    chk("R4 underflow rdata zero", eng_rdata, 0);

    // R5 error flag clear
    step(0, 0, 0, 3'b110, 0, 0);
    chk("R5 ovf cleared", ovf_flag, 0);
    chk("R5 unf cleared", unf_flag, 0);

    // R8 mid-run reset
    step(1, 8'h5A, 0, 3'b000, 0, 0);
    rst_n = 1'b0;
    step(0, 0, 0, 3'b000, 0, 0);
    chk("R8 rdata after reset", eng_rdata, 0);
    chk("R8 inv after reset", invert_req, 0);
    chk("R8 trig after reset", trig_flag, 0);
    rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule